// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block holds the eight-bit status word of an I2C peripheral. It watches the SCL and SDA lines through synchronizers and finds start and stop conditions on them. It counts the clocks of every byte, so it can pick up the read/write bit of an address byte and the acknowledge level of the ninth clock.

It also takes single-cycle event strobes from the controller core. These are: arbitration lost, slave address hit or miss, general call received, a software write of 0 to the interrupt bit, and a software request for mastership. A level input tells it whether the device is currently master. Each flag follows its own set and clear rules. Software reads the result on a plain output word.

Top module: `i2c_stat_track`

## Requirements
- R1: The status word is `{busy, rstart, arb_lost, nack, xmit, slave_hit, gen_call, first}` from bit 7 down to bit 0. Every bit reads 0 after a synchronous reset.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The busy bit (7) sets on a start and clears on a stop.
- R3: The repeated-start bit (6) sets on a start seen while busy is 1. It clears on a start seen while busy is 0. It also clears on a stop, on an interrupt-clear write and on an address miss.
- R4: The arbitration-lost bit (5) sets on the arbitration-lost strobe. It also sets on a mastership request while busy is 1 and master is 0. It clears on an interrupt-clear write.
- R5: The nack bit (4) takes the SDA level at the ninth SCL rising edge of each byte, giving 1 for no acknowledge and 0 for acknowledge. It is forced to 0 by any start or stop.
- R6: At the eighth SCL rising edge of the first byte after a start, the transfer bit (3) loads the inverted SDA level when master is 1 and the SDA level itself when master is 0. It holds that value until the next address byte.
- R7: The slave-hit bit (2) sets on an address-hit strobe while master is 0, and clears on any start or stop.
- R8: The general-call bit (1) sets on a general-call strobe while master is 0, and clears on any start or stop.
- R9: The first-byte bit (0) sets on every start. It clears on an interrupt-clear write or an address miss.
- R10: When a set event and a clear event for the same bit land in the same cycle, the bit ends up 1. This includes a start in the same cycle as an interrupt-clear write.
- R11: SDA changes while SCL is low are not conditions: they leave the busy bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| arb_lost_i | input | 1 | Strobe: arbitration lost during master transmit |
| addr_hit_i | input | 1 | Strobe: own slave address matched |
| addr_miss_i | input | 1 | Strobe: slave address did not match |
| gcall_i | input | 1 | Strobe: general call address received |
| master_i | input | 1 | Level: device is currently master |
| irq_clr_i | input | 1 | Strobe: software wrote 0 to the interrupt bit |
| master_req_i | input | 1 | Strobe: software requested mastership |
| status_o | output | 8 | Status word, read only |

## Verification
The collision that matters is a start condition found on the bus in the same cycle as a software interrupt-clear write. The start sets the first-byte bit and may set the repeated-start bit, while the clear write drops both of them.

The bench provokes this by raising the clear strobe exactly three clock edges after it lowers SDA under a high SCL, which is the cycle the start strobe reaches the flag register. It then expects first-byte to be 1, arbitration-lost to be 0, and repeated-start to equal the prior busy bit. Random event bursts also put several set and clear strobes together in one cycle, and each result is judged with the set-wins rule.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic busy;
        logic rstart;
        logic arb_lost;
        logic nack;
        logic xmit;
        logic slave_hit;
        logic gen_call;
        logic first;
    } stat_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic arb_lost;
        logic addr_hit;
        logic addr_miss;
        logic gcall;
        logic irq_clr;
        logic master_req;
        logic master;
    } core_ev_t;

    // set has priority over clear
    function automatic logic flag_upd(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    // a master sending a write address transmits; a slave asked to read transmits
    function automatic logic xmit_dir(logic master, logic rw);
        return master ? ~rw : rw;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_s, sda_s, scl_q, sda_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_bit_cnt.sv
module i2c_bit_cnt #(
    parameter int BITS_PER_BYTE = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic scl_rise,
    output logic rw_stb,
    output logic ack_stb
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] RWB  = CNT_W'(BITS_PER_BYTE - 2);

    logic [CNT_W-1:0] cnt;
    logic             addr_phase;

    assign ack_stb = scl_rise & ~start & (cnt == LAST);
    assign rw_stb  = scl_rise & ~start & addr_phase & (cnt == RWB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            addr_phase <= 1'b0;
        end else begin
            if (start)
                cnt <= '0;
            else if (scl_rise)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;

            if (start)
                addr_phase <= 1'b1;
            else if (ack_stb || stop)
                addr_phase <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_flag_reg.sv
module i2c_flag_reg
    import i2c_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     stop,
    input  logic     sda,
    input  logic     rw_stb,
    input  logic     ack_stb,
    input  core_ev_t cev,
    output stat_t    stat
);
    stat_t nxt;
    logic  cond;

    always_comb begin
        cond          = start | stop;
        nxt.busy      = flag_upd(stat.busy, start, stop);
        nxt.rstart    = flag_upd(stat.rstart, start & stat.busy,
                                 cev.irq_clr | cev.addr_miss | stop | (start & ~stat.busy));
        nxt.arb_lost  = flag_upd(stat.arb_lost,
                                 cev.arb_lost | (cev.master_req & stat.busy & ~cev.master),
                                 cev.irq_clr);
        nxt.nack      = ack_stb ? sda : (cond ? 1'b0 : stat.nack);
        nxt.xmit      = rw_stb ? xmit_dir(cev.master, sda) : stat.xmit;
        nxt.slave_hit = flag_upd(stat.slave_hit, cev.addr_hit & ~cev.master, cond);
        nxt.gen_call  = flag_upd(stat.gen_call, cev.gcall & ~cev.master, cond);
        nxt.first     = flag_upd(stat.first, start, cev.irq_clr | cev.addr_miss);
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end
endmodule

// File: rtl/i2c_stat_track.sv
module i2c_stat_track
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_BYTE = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              arb_lost_i,
    input  logic              addr_hit_i,
    input  logic              addr_miss_i,
    input  logic              gcall_i,
    input  logic              master_i,
    input  logic              irq_clr_i,
    input  logic              master_req_i,
    output logic [STAT_W-1:0] status_o
);
    bus_ev_t  bev;
    core_ev_t cev;
    stat_t    stat;
    logic     rw_stb, ack_stb;

    assign cev = '{arb_lost: arb_lost_i, addr_hit: addr_hit_i, addr_miss: addr_miss_i,
                   gcall: gcall_i, irq_clr: irq_clr_i, master_req: master_req_i,
                   master: master_i};

    i2c_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(bev)
    );

    i2c_bit_cnt #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_cnt (
        .clk(clk), .rst(rst), .start(bev.start), .stop(bev.stop),
        .scl_rise(bev.scl_rise), .rw_stb(rw_stb), .ack_stb(ack_stb)
    );

    i2c_flag_reg u_flags (
        .clk(clk), .rst(rst), .start(bev.start), .stop(bev.stop), .sda(bev.sda),
        .rw_stb(rw_stb), .ack_stb(ack_stb), .cev(cev), .stat(stat)
    );

    assign status_o = stat;
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       stop,
    input logic       sda,
    input logic       ack_stb,
    input logic       arb_in,
    input logic       hit_in,
    input logic [7:0] status
);
    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> status[7]);
    p_stop_clears_busy_r2: assert property (@(posedge clk) disable iff (rst)
        stop |=> !status[7]);
    p_rstart_when_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (start && status[7]) |=> status[6]);
    p_rstart_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !status[7]) |=> !status[6]);
    p_arb_sets_r4: assert property (@(posedge clk) disable iff (rst)
        arb_in |=> status[5]);
    p_ack_capture_r5: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> (status[4] == $past(sda)));
    p_cond_clears_nack_r5: assert property (@(posedge clk) disable iff (rst)
        ((start || stop) && !ack_stb) |=> !status[4]);
    p_cond_clears_hit_r7: assert property (@(posedge clk) disable iff (rst)
        ((start || stop) && !hit_in) |=> !status[2]);
    p_start_sets_first_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> status[0]);
endmodule

bind i2c_stat_track i2c_stat_chk u_chk (
    .clk(clk), .rst(rst), .start(bev.start), .stop(bev.stop), .sda(bev.sda),
    .ack_stb(ack_stb), .arb_in(arb_lost_i), .hit_in(addr_hit_i), .status(status_o)
);

// File: tb/sim_i2c_stat_track.sv
module sim_i2c_stat_track;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1;
    logic arb = 0, hit = 0, miss = 0, gc = 0, mst = 0, iclr = 0, mreq = 0;
    logic [7:0] status;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] exp_s = '0;
    int  cnt = 0;
    bit  addr = 0;

    localparam int BB = 7, RS = 6, AL = 5, NK = 4, TX = 3, SH = 2, GC = 1, FB = 0;

    always #4 clk = ~clk;

    i2c_stat_track u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .arb_lost_i(arb), .addr_hit_i(hit), .addr_miss_i(miss), .gcall_i(gc),
        .master_i(mst), .irq_clr_i(iclr), .master_req_i(mreq), .status_o(status)
    );

    task automatic chk(input string req);
        checks++;
        if (status !== exp_s) begin
            errors++;
            $display("FAIL %s: status=%b expected=%b", req, status, exp_s);
        end
    endtask

    task automatic bus(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (7) @(negedge clk);
    endtask

    function automatic void m_rise(input logic d);
        if (cnt == 7 && addr) exp_s[TX] = mst ? ~d : d;
        if (cnt == 8) begin
            exp_s[NK] = d;
            addr = 0;
            cnt = 0;
        end else cnt++;
    endfunction

    function automatic void m_start();
        exp_s[RS] = exp_s[BB];
        exp_s[BB] = 1;
        exp_s[NK] = 0;
        exp_s[SH] = 0;
        exp_s[GC] = 0;
        exp_s[FB] = 1;
        cnt = 0;
        addr = 1;
    endfunction

    function automatic void m_stop();
        exp_s[BB] = 0;
        exp_s[RS] = 0;
        exp_s[NK] = 0;
        exp_s[SH] = 0;
        exp_s[GC] = 0;
        addr = 0;
    endfunction

    function automatic logic swin(input logic cur, input logic s, input logic c);
        return s ? 1'b1 : (c ? 1'b0 : cur);
    endfunction

    task automatic do_start(input bit clr_same);
        bus(0, sda);
        bus(0, 1);
        bus(1, 1);
        m_rise(1);
        @(negedge clk);
        sda = 0;
        if (clr_same) begin
            @(negedge clk);
            @(negedge clk);
            iclr = 1;
            @(negedge clk);
            iclr = 0;
            repeat (4) @(negedge clk);
        end else repeat (7) @(negedge clk);
        m_start();
        if (clr_same) exp_s[AL] = 0;
        bus(0, 0);
    endtask

    task automatic do_stop();
        bus(0, sda);
        bus(0, 0);
        bus(1, 0);
        m_rise(0);
        bus(1, 1);
        m_stop();
    endtask

    task automatic do_byte(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) begin
            bus(0, b[i]);
            bus(1, b[i]);
            m_rise(b[i]);
        end
        bus(0, ack);
        bus(1, ack);
        m_rise(ack);
        bus(0, ack);
    endtask

    task automatic pulse(input logic [5:0] e);
        logic al_s, al_c, rs_c;
        @(negedge clk);
        {arb, hit, miss, gc, iclr, mreq} = e;
        @(negedge clk);
        {arb, hit, miss, gc, iclr, mreq} = '0;
        al_s = e[5] | (e[0] & exp_s[BB] & ~mst);
        al_c = e[1];
        rs_c = e[1] | e[3];
        exp_s[AL] = swin(exp_s[AL], al_s, al_c);
        exp_s[RS] = swin(exp_s[RS], 1'b0, rs_c);
        exp_s[FB] = swin(exp_s[FB], 1'b0, rs_c);
        exp_s[SH] = swin(exp_s[SH], e[4] & ~mst, 1'b0);
        exp_s[GC] = swin(exp_s[GC], e[2] & ~mst, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c2a));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset");

        // R11: SDA toggles under low SCL are no condition
        bus(0, 1);
        bus(0, 0);
        bus(0, 1);
        chk("R11 sda under low scl");
        bus(1, 1);
        m_rise(1);
        chk("R11 scl back high");

        do_start(0);
        chk("R2 R3 R9 start on idle bus");
        mst = 1;
        do_byte(8'hA4, 0);
        chk("R6 master write address, R5 ack");
        mreq = 0;
        pulse(6'b000001);
        chk("R4 master request while master");
        do_byte(8'h3C, 1);
        chk("R5 nack captured, R6 held");
        do_start(0);
        chk("R3 repeated start");
        do_byte(8'hA5, 0);
        chk("R6 master read address");
        do_stop();
        chk("R2 R5 stop clears");
        mst = 0;
        do_start(0);
        do_byte(8'h00, 0);
        pulse(6'b010100);
        chk("R7 R8 slave hit and general call");
        pulse(6'b000001);
        chk("R4 request while other holds bus");
        do_start(1);
        chk("R10 start with interrupt clear");
        pulse(6'b100010);
        chk("R10 arb lost with clear");
        pulse(6'b001000);
        chk("R3 R9 address miss");
        do_stop();
        do_start(1);
        chk("R10 start on idle with clear");

        for (int n = 0; n < 120; n++) begin
            int op;
            op = $urandom % 5;
            if (op == 0) begin
                do_start(($urandom % 4) == 0);
                chk("R2 R3 R9 R10 random start");
            end else if (op == 1 && exp_s[BB]) begin
                do_stop();
                chk("R2 R5 R7 random stop");
            end else if (op == 2 && exp_s[BB]) begin
                do_byte(8'($urandom), 1'($urandom));
                chk("R5 R6 random byte");
            end else if (op == 3) begin
                pulse(6'($urandom));
                chk("R4 R7 R8 R9 R10 random events");
            end else begin
                mst = 1'($urandom);
                @(negedge clk);
                chk("R1 hold");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule